// File: doc/BRIEF.md
# Content-Searchable Word Store with Miss Flag

This block is a small word store that behaves like an ordinary random-access memory for addressed reads and writes, and can also be searched by content. A search presents a key. The key is compared against every stored word at the same time, and each word has its own comparator. The comparison result is captured as a match vector with one bit per word. Several bits may be set at once when more than one word holds the key. A miss flag is the NOR of all match bits, so it is high when no word holds the key.

Each word carries a valid bit, which reset clears. A word that has never been written can never match, and reads of it return zero. An addressed access and a search cannot share a cycle. When a write or a read is requested in the same cycle as a search, the addressed access is carried out, the search is dropped and the previous match result stays on the outputs. The comparator tree that forms the miss flag is chosen by a parameter: one flat reduction, or a balanced tree of two-input ORs.

Top module: `assoc_mem`

## Requirements
- R1: A write (`wr_en_i` high) stores `wr_data_i` at word `addr_i` and marks that word valid from the next cycle.
- R2: A read (`rd_en_i` high) presents the word at `addr_i` on `rd_data_o` one clock later. A read and a write to the same word in the same cycle return the contents held before that write. When there is no read, `rd_data_o` holds its value.
- R3: Reading a word that has not been written since reset returns all zeros.
- R4: An accepted search compares `key_i` with every valid word and, one clock later, shows on `match_o` a vector whose bit i is 1 exactly when word i holds the key. Any number of bits may be set.
- R5: A word whose valid bit is clear never matches. This holds even when the key equals that word's reset contents, which are zero.
- R6: `miss_o` is 1 exactly when every bit of `match_o` is 0.
- R7: When a write and a search are requested in one cycle, the write is performed, the search is ignored and `match_o` keeps its previous value.
- R8: When a read and a search are requested in one cycle, the read is performed, the search is ignored and `match_o` keeps its previous value.
- R9: In a cycle with no accepted search, `match_o` keeps its value.
- R10: After reset, all words are invalid, `match_o` is all zeros, `miss_o` is 1 and `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | $clog2(WORDS) | Word address for reads and writes |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | WIDTH | Data to write |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | WIDTH | Registered read data |
| srch_en_i | input | 1 | Search request |
| key_i | input | WIDTH | Search key |
| match_o | output | WORDS | Registered per-word match vector |
| miss_o | output | 1 | High when no match bit is set |

## Verification
A search can coincide with either an addressed write or an addressed read, and those collisions are the interesting cases. Directed cycles first raise a search together with a write whose data equals the key, and then a search together with a read. The random phase issues all three requests independently, so such collisions also occur many times. In every collision the check is the same: the match vector must hold the value left by the last accepted search, and the addressed operation must still take effect. For a write, a later read or search must show the new data. For a read, the read data must appear one clock later.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

   // Structure used to reduce the match lines into the miss flag
   typedef enum logic [0:0] {
      MISS_FLAT = 1'b0,
      MISS_TREE = 1'b1
   } miss_style_e;

endpackage

// File: rtl/assoc_row.sv
module assoc_row #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic [WIDTH-1:0] key_i,
   output logic             hit_o,
   output logic             valid_o,
   output logic [WIDTH-1:0] word_o
);

   logic [WIDTH-1:0] data_q;
   logic             valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         valid_q <= 1'b0;
      end else if (we_i) begin
         data_q  <= wdata_i;
         valid_q <= 1'b1;
      end
   end

   // One comparator per word; an empty word never raises its line
   assign hit_o   = valid_q && (data_q == key_i);
   assign valid_o = valid_q;
   assign word_o  = valid_q ? data_q : '0;

   AST_ROW_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (valid_o && word_o == $past(wdata_i))) else $error("row write lost"); // R1

endmodule

// File: rtl/assoc_miss.sv
module assoc_miss
   import assoc_pkg::*;
#(
   parameter int          N     = 8,
   parameter miss_style_e STYLE = MISS_TREE
) (
   input  logic [N-1:0] match_i,
   output logic         miss_o
);

   if (STYLE == MISS_FLAT) begin : g_flat
      assign miss_o = ~(|match_i);
   end else begin : g_tree
      localparam int LVLS = (N > 1) ? $clog2(N) : 1;
      localparam int P    = 1 << LVLS;
      logic node [2*P-1];
      for (genvar l = 0; l < P; l++) begin : g_leaf
         if (l < N) begin : g_used
            assign node[P-1+l] = match_i[l];
         end else begin : g_pad
            assign node[P-1+l] = 1'b0;
         end
      end
      for (genvar k = 0; k < P-1; k++) begin : g_or
         assign node[k] = node[2*k+1] | node[2*k+2];
      end
      assign miss_o = ~node[0];
   end

endmodule

// File: rtl/assoc_mem.sv
module assoc_mem
   import assoc_pkg::*;
#(
   parameter int          WORDS      = 8,
   parameter int          WIDTH      = 16,
   parameter miss_style_e MISS_STYLE = MISS_TREE,
   localparam int         AW         = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr_i,
   input  logic             wr_en_i,
   input  logic [WIDTH-1:0] wr_data_i,
   input  logic             rd_en_i,
   output logic [WIDTH-1:0] rd_data_o,
   input  logic             srch_en_i,
   input  logic [WIDTH-1:0] key_i,
   output logic [WORDS-1:0] match_o,
   output logic             miss_o
);

   if (WORDS < 2) begin : g_bad_words
      $error("assoc_mem: WORDS must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("assoc_mem: WIDTH must be at least 1");
   end

   logic [WORDS-1:0] hit_w;
   logic [WORDS-1:0] valid_w;
   logic [WIDTH-1:0] word_w [WORDS];
   logic             addr_ok;
   logic             srch_go;
   logic [WIDTH-1:0] rd_mux;
   logic [WIDTH-1:0] rd_q;
   logic [WORDS-1:0] match_q;

   assign addr_ok = (int'(addr_i) < WORDS);
   // Addressed access owns the array; a colliding search is dropped
   assign srch_go = srch_en_i && !wr_en_i && !rd_en_i;

   for (genvar i = 0; i < WORDS; i++) begin : g_row
      assoc_row #(.WIDTH(WIDTH)) u_row (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_i    (wr_en_i && addr_ok && (int'(addr_i) == i)),
         .wdata_i (wr_data_i),
         .key_i   (key_i),
         .hit_o   (hit_w[i]),
         .valid_o (valid_w[i]),
         .word_o  (word_w[i])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < WORDS; i++) begin
         if (addr_ok && int'(addr_i) == i) rd_mux = word_w[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q    <= '0;
         match_q <= '0;
      end else begin
         if (rd_en_i) rd_q    <= rd_mux;
         if (srch_go) match_q <= hit_w;
      end
   end

   assoc_miss #(.N(WORDS), .STYLE(MISS_STYLE)) u_miss (
      .match_i (match_q),
      .miss_o  (miss_o)
   );

   assign rd_data_o = rd_q;
   assign match_o   = match_q;

   AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o & ~valid_w) == '0) else $error("invalid word flagged"); // R5
   AST_MISS_IS_NOR: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o == (match_o == '0)) else $error("miss flag wrong"); // R6
   AST_WRITE_BEATS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && srch_en_i) |=> $stable(match_o)) else $error("search ran with write"); // R7
   AST_READ_BEATS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && srch_en_i) |=> $stable(match_o)) else $error("search ran with read"); // R8
   AST_IDLE_HOLDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_en_i |=> $stable(match_o)) else $error("match moved without search"); // R9
   AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && addr_ok && !valid_w[addr_i]) |=> (rd_data_o == '0)) else $error("empty read nonzero"); // R3
   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rd_data_o)) else $error("read data moved"); // R2

endmodule

// File: tb/assoc_mem_bench.sv
module assoc_mem_bench;

   localparam int WORDS = 8;
   localparam int WIDTH = 16;
   localparam int AW    = $clog2(WORDS);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [AW-1:0]    addr_i = '0;
   logic             wr_en_i = 1'b0;
   logic [WIDTH-1:0] wr_data_i = '0;
   logic             rd_en_i = 1'b0;
   logic [WIDTH-1:0] rd_data_o;
   logic             srch_en_i = 1'b0;
   logic [WIDTH-1:0] key_i = '0;
   logic [WORDS-1:0] match_o;
   logic             miss_o;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [WIDTH-1:0] m_data [WORDS];
   logic [WORDS-1:0] m_valid;
   logic [WORDS-1:0] m_match;
   logic [WIDTH-1:0] m_rd;

   always #5 clk = ~clk;

   assoc_mem #(.WORDS(WORDS), .WIDTH(WIDTH)) u_assoc_mem (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
      .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
      .srch_en_i(srch_en_i), .key_i(key_i), .match_o(match_o), .miss_o(miss_o)
   );

   function automatic logic [WORDS-1:0] exp_hits(input logic [WIDTH-1:0] k);
      logic [WORDS-1:0] v = '0;
      for (int i = 0; i < WORDS; i++) v[i] = m_valid[i] && (m_data[i] == k);
      return v;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string mtag, input string rtag);
      chk(mtag, 32'(match_o), 32'(m_match));
      chk("R6 miss", 32'(miss_o), 32'(m_match == '0));
      chk(rtag, 32'(rd_data_o), 32'(m_rd));
   endtask

   // Drive at the falling edge, let the model follow the rising edge, compare at the next falling edge
   task automatic step(input bit wr, input bit rd, input bit sr, input int a,
                       input logic [WIDTH-1:0] wd, input logic [WIDTH-1:0] k,
                       input string mtag, input string rtag);
      wr_en_i = wr; rd_en_i = rd; srch_en_i = sr;
      addr_i = AW'(a); wr_data_i = wd; key_i = k;
      @(posedge clk);
      if (rd) m_rd = m_valid[a] ? m_data[a] : '0;
      if (sr && !wr && !rd) m_match = exp_hits(k);
      if (wr) begin m_data[a] = wd; m_valid[a] = 1'b1; end
      @(negedge clk);
      wr_en_i = 1'b0; rd_en_i = 1'b0; srch_en_i = 1'b0;
      check_all(mtag, rtag);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1C0DE5));
      for (int i = 0; i < WORDS; i++) m_data[i] = '0;
      m_valid = '0; m_match = '0; m_rd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 match", 32'(match_o), 32'h0);
      chk("R10 miss", 32'(miss_o), 32'h1);
      chk("R10 rdata", 32'(rd_data_o), 32'h0);
      // R5: key zero equals reset contents, still no hit
      step(0, 0, 1, 0, '0, 16'h0000, "R5 empty key0", "R10 rdata");
      // R3: unwritten words read zero
      for (int a = 0; a < WORDS; a++) step(0, 1, 0, a, '0, '0, "R9 hold", "R3 empty read");
      // R1/R2: writes, then read back
      step(1, 0, 0, 0, 16'hA5A5, '0, "R9 hold", "R2 hold");
      step(1, 0, 0, 3, 16'hA5A5, '0, "R9 hold", "R2 hold");
      step(1, 0, 0, 7, 16'h1234, '0, "R9 hold", "R2 hold");
      step(0, 1, 0, 3, '0, '0, "R9 hold", "R1 R2 readback");
      // R4 multi-hit, single hit, and miss
      step(0, 0, 1, 0, '0, 16'hA5A5, "R4 multi-hit", "R2 hold");
      step(0, 0, 1, 0, '0, 16'h1234, "R4 single hit", "R2 hold");
      step(0, 0, 1, 0, '0, 16'hBEEF, "R4 R6 no hit", "R2 hold");
      step(0, 0, 1, 0, '0, 16'h1234, "R4 single hit", "R2 hold");
      // R7: write colliding with search whose key equals the new data
      step(1, 0, 1, 5, 16'hBEEF, 16'hBEEF, "R7 write wins", "R2 hold");
      step(0, 0, 1, 0, '0, 16'hBEEF, "R7 write landed", "R2 hold");
      // R8: read colliding with search
      step(0, 1, 1, 7, '0, 16'hA5A5, "R8 read wins", "R8 read done");
      // R2: read and write same word same cycle return old contents
      step(1, 1, 0, 7, 16'h5555, '0, "R9 hold", "R2 read-before-write");
      step(0, 1, 0, 7, '0, '0, "R9 hold", "R1 new data");
      // Random phase: small value space to force multi-hits and collisions
      for (int n = 0; n < 400; n++) begin
         bit wr = ($urandom % 4) == 0;
         bit rd = ($urandom % 4) == 0;
         bit sr = ($urandom % 2) == 0;
         int a  = $urandom % WORDS;
         logic [WIDTH-1:0] wd = WIDTH'($urandom % 4);
         logic [WIDTH-1:0] k  = WIDTH'($urandom % 5);
         step(wr, rd, sr, a, wd, k, "R4 R7 R8 R9 random", "R2 R3 random");
      end
      // R10 again after a mid-run reset
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < WORDS; i++) m_data[i] = '0;
      m_valid = '0; m_match = '0; m_rd = '0;
      @(negedge clk);
      check_all("R10 match after reset", "R10 rdata after reset");
      step(0, 1, 0, 0, '0, '0, "R9 hold", "R3 R10 cleared");
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule